// File: doc/BRIEF.md
# Per-Crossing Stub Count Limiter

This block sits after the stub matching stage of a two-section chamber trigger. Each beam crossing presents, for both sections A and B, a set of matched-stub valid bits. The bits are arranged in slots indexed by timing offset, and each slot holds a first and a second stub position. The block limits how many of these stubs survive for that crossing, in two steps applied in sequence.

The first step is an optional trim. It runs when the algorithm select chooses it and either section holds more than two stubs. It visits the slots from the centre of the matching window outward and keeps at most two stubs in each section. The second step is a total cap across both sections. When the combined count exceeds the programmed maximum, every section B stub is kept, and section A stubs are kept in rising offset order only while room remains. The surviving bits and the final counts per section come out one cycle after the crossing is presented. A bin index tags each crossing, and a done flag marks the last bin of each frame.

Top module: `stub_count_limiter`

## Requirements
- R1: After reset, out_valid_o, done_o, bin_o, both stub vectors and both counts are zero.
- R2: A crossing presented with in_valid_i high is reported with out_valid_o high exactly one cycle later. With in_valid_i low, out_valid_o is low on the next cycle and the stub outputs keep their values.
- R3: Stub bit 2*k+p belongs to slot k, position p (p=0 first, p=1 second). Slots with k greater than or equal to win_size_i count as empty and are cleared at the output.
- R4: An output stub bit is never set unless the matching input bit was set.
- R5: The trim is applied only when algo_sel_i equals 1 and either section holds more than 2 valid stubs in the window. Any other algo_sel_i code (0, 2, 3) leaves both sections untouched by the trim.
- R6: The trim visits slots in the order centre, centre-1, centre+1, centre-2, centre+2, and so on, where centre = win_size_i/2. Within a slot, position 0 comes before position 1. The first two valid stubs of each section are kept and the rest are cleared.
- R7: When algo_sel_i equals 1, neither output count exceeds 2.
- R8: If the count of A plus the count of B exceeds max_total_i after the trim, all section B stubs are kept. Section A stubs are then kept in ascending bit index while the running total stays at or below max_total_i, and the rest are cleared.
- R9: When the total is at or below max_total_i (including the no-cap value 999), the cap changes nothing.
- R10: cnt_a_o and cnt_b_o equal the number of set bits in sec_a_o and sec_b_o.
- R11: bin_o counts accepted crossings from 0 to NUM_BINS-1 and wraps to 0. done_o is high together with the output of bin NUM_BINS-1 and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A crossing is presented this cycle |
| sec_a_i | input | 2*MAX_SLOTS | Section A stub valid bits, bit 2*slot+position |
| sec_b_i | input | 2*MAX_SLOTS | Section B stub valid bits, bit 2*slot+position |
| win_size_i | input | $clog2(MAX_SLOTS+1) | Matching window size, odd, at most MAX_SLOTS |
| algo_sel_i | input | 2 | Cross-crossing algorithm select, 1 enables the trim |
| max_total_i | input | CAP_W | Maximum stubs per crossing over both sections |
| out_valid_o | output | 1 | Results for one crossing are valid |
| sec_a_o | output | 2*MAX_SLOTS | Section A stubs kept |
| sec_b_o | output | 2*MAX_SLOTS | Section B stubs kept |
| cnt_a_o | output | $clog2(2*MAX_SLOTS+1) | Section A final count |
| cnt_b_o | output | $clog2(2*MAX_SLOTS+1) | Section B final count |
| bin_o | output | $clog2(NUM_BINS) | Crossing bin index of the reported result |
| done_o | output | 1 | Last bin of the frame is being reported |

## Verification
A wrong preference rank or a wrong trim counter shows up at the very next output. The wrong stubs survive in a section, and this shows only for crossings that place stubs in several slots, on both sides of the centre. A cap walk that runs in the wrong direction, or that also counts section B, clears the wrong section A bits, or clears section B bits, in the same cycle. A bin counter that drifts makes done_o appear on the wrong crossing, which is visible only at the frame boundary. For that reason the directed tests run a full frame and step across the wrap.

// File: rtl/stub_limit_pkg.sv
package stub_limit_pkg;
  typedef enum logic [1:0] {
    ALGO_NONE = 2'd0,
    ALGO_PREF = 2'd1,
    ALGO_RSV2 = 2'd2,
    ALGO_RSV3 = 2'd3
  } algo_e;

  localparam int NUM_SEC = 2;
  localparam int SEC_A   = 0;
  localparam int SEC_B   = 1;
endpackage

// File: rtl/stub_pref_trim.sv
module stub_pref_trim #(
  parameter int MAX_SLOTS = 15,
  localparam int STUBS  = 2 * MAX_SLOTS,
  localparam int SLOT_W = $clog2(MAX_SLOTS + 1),
  localparam int RANK_W = $clog2(2 * MAX_SLOTS + 1)
) (
  input  logic [STUBS-1:0]  valid_i,
  input  logic [SLOT_W-1:0] win_i,
  input  logic              en_i,
  output logic [STUBS-1:0]  valid_o
);
  logic [RANK_W-1:0] rank [MAX_SLOTS];

  // centre-out rank: centre 0, centre-d -> 2d-1, centre+d -> 2d
  always_comb begin
    int ctr;
    ctr = int'(win_i) / 2;
    for (int k = 0; k < MAX_SLOTS; k++) begin
      if (k == ctr)     rank[k] = '0;
      else if (k < ctr) rank[k] = RANK_W'(2 * (ctr - k) - 1);
      else              rank[k] = RANK_W'(2 * (k - ctr));
    end
  end

  always_comb begin
    int kept;
    kept = 0;
    if (!en_i) begin
      valid_o = valid_i;
    end else begin
      valid_o = '0;
      for (int r = 0; r < MAX_SLOTS; r++) begin
        for (int k = 0; k < MAX_SLOTS; k++) begin
          if (rank[k] == RANK_W'(r)) begin
            for (int p = 0; p < 2; p++) begin
              if (valid_i[2*k+p] && kept < 2) begin
                valid_o[2*k+p] = 1'b1;
                kept = kept + 1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/stub_total_cap.sv
module stub_total_cap #(
  parameter int MAX_SLOTS = 15,
  parameter int CAP_W     = 10,
  localparam int STUBS = 2 * MAX_SLOTS
) (
  input  logic [STUBS-1:0] a_i,
  input  logic [STUBS-1:0] b_i,
  input  logic [CAP_W-1:0] max_i,
  output logic [STUBS-1:0] a_o
);
  always_comb begin
    int run;
    int lim;
    lim = int'(max_i);
    run = $countones(b_i);
    if ($countones(a_i) + run <= lim) begin
      a_o = a_i;
    end else begin
      a_o = '0;
      for (int i = 0; i < STUBS; i++) begin
        if (a_i[i] && run < lim) begin
          a_o[i] = 1'b1;
          run = run + 1;
        end
      end
    end
  end
endmodule

// File: rtl/stub_count_limiter.sv
module stub_count_limiter
  import stub_limit_pkg::*;
#(
  parameter int MAX_SLOTS = 15,
  parameter int NUM_BINS  = 16,
  parameter int CAP_W     = 10,
  localparam int STUBS  = 2 * MAX_SLOTS,
  localparam int SLOT_W = $clog2(MAX_SLOTS + 1),
  localparam int CNT_W  = $clog2(STUBS + 1),
  localparam int BIN_W  = $clog2(NUM_BINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [STUBS-1:0]  sec_a_i,
  input  logic [STUBS-1:0]  sec_b_i,
  input  logic [SLOT_W-1:0] win_size_i,
  input  logic [1:0]        algo_sel_i,
  input  logic [CAP_W-1:0]  max_total_i,
  output logic              out_valid_o,
  output logic [STUBS-1:0]  sec_a_o,
  output logic [STUBS-1:0]  sec_b_o,
  output logic [CNT_W-1:0]  cnt_a_o,
  output logic [CNT_W-1:0]  cnt_b_o,
  output logic [BIN_W-1:0]  bin_o,
  output logic              done_o
);
  logic [STUBS-1:0] win_mask;
  logic [STUBS-1:0] sec_in  [NUM_SEC];
  logic [STUBS-1:0] sec_trm [NUM_SEC];
  logic [STUBS-1:0] a_cap;
  logic             trim_en;
  logic [BIN_W-1:0] bin_q;

  for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_mask
    assign win_mask[2*k]   = (SLOT_W'(k) < win_size_i);
    assign win_mask[2*k+1] = (SLOT_W'(k) < win_size_i);
  end

  assign sec_in[SEC_A] = sec_a_i & win_mask;
  assign sec_in[SEC_B] = sec_b_i & win_mask;

  assign trim_en = (algo_e'(algo_sel_i) == ALGO_PREF) &&
                   (($countones(sec_in[SEC_A]) > 2) || ($countones(sec_in[SEC_B]) > 2));

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    stub_pref_trim #(.MAX_SLOTS(MAX_SLOTS)) u_trim (
      .valid_i (sec_in[s]),
      .win_i   (win_size_i),
      .en_i    (trim_en),
      .valid_o (sec_trm[s])
    );
  end

  stub_total_cap #(.MAX_SLOTS(MAX_SLOTS), .CAP_W(CAP_W)) u_cap (
    .a_i   (sec_trm[SEC_A]),
    .b_i   (sec_trm[SEC_B]),
    .max_i (max_total_i),
    .a_o   (a_cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sec_a_o     <= '0;
      sec_b_o     <= '0;
      cnt_a_o     <= '0;
      cnt_b_o     <= '0;
      bin_o       <= '0;
      bin_q       <= '0;
      done_o      <= 1'b0;
    end else if (in_valid_i) begin
      out_valid_o <= 1'b1;
      sec_a_o     <= a_cap;
      sec_b_o     <= sec_trm[SEC_B];
      cnt_a_o     <= CNT_W'($countones(a_cap));
      cnt_b_o     <= CNT_W'($countones(sec_trm[SEC_B]));
      bin_o       <= bin_q;
      done_o      <= (bin_q == BIN_W'(NUM_BINS - 1));
      bin_q       <= (bin_q == BIN_W'(NUM_BINS - 1)) ? '0 : bin_q + 1'b1;
    end else begin
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
    end
  end
endmodule

// File: rtl/stub_count_limiter_chk.sv
module stub_count_limiter_chk #(
  parameter int MAX_SLOTS = 15,
  parameter int NUM_BINS  = 16,
  parameter int CAP_W     = 10,
  localparam int STUBS  = 2 * MAX_SLOTS,
  localparam int SLOT_W = $clog2(MAX_SLOTS + 1),
  localparam int CNT_W  = $clog2(STUBS + 1),
  localparam int BIN_W  = $clog2(NUM_BINS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [STUBS-1:0]  sec_a_i,
  input logic [STUBS-1:0]  sec_b_i,
  input logic [1:0]        algo_sel_i,
  input logic [CAP_W-1:0]  max_total_i,
  input logic              out_valid_o,
  input logic [STUBS-1:0]  sec_a_o,
  input logic [STUBS-1:0]  sec_b_o,
  input logic [CNT_W-1:0]  cnt_a_o,
  input logic [CNT_W-1:0]  cnt_b_o,
  input logic [BIN_W-1:0]  bin_o,
  input logic              done_o
);
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(sec_a_o) && $stable(sec_b_o)));
  a_r4_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (((sec_a_o & ~$past(sec_a_i)) == '0) && ((sec_b_o & ~$past(sec_b_i)) == '0)));
  a_r7_trim_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && algo_sel_i == 2'd1) |=> (cnt_a_o <= 2 && cnt_b_o <= 2));
  a_r8_cap_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ((32'(cnt_a_o) + 32'(cnt_b_o) <= 32'($past(max_total_i))) || cnt_a_o == '0));
  a_r10_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (32'(cnt_a_o) == $countones(sec_a_o) && 32'(cnt_b_o) == $countones(sec_b_o)));
  a_r11_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_valid_o && bin_o == BIN_W'(NUM_BINS - 1)));
endmodule

bind stub_count_limiter stub_count_limiter_chk #(
  .MAX_SLOTS(MAX_SLOTS), .NUM_BINS(NUM_BINS), .CAP_W(CAP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .sec_a_i(sec_a_i), .sec_b_i(sec_b_i), .algo_sel_i(algo_sel_i),
  .max_total_i(max_total_i), .out_valid_o(out_valid_o),
  .sec_a_o(sec_a_o), .sec_b_o(sec_b_o), .cnt_a_o(cnt_a_o),
  .cnt_b_o(cnt_b_o), .bin_o(bin_o), .done_o(done_o)
);

// File: tb/tb_stub_count_limiter.sv
`timescale 1ns/1ps
module tb_stub_count_limiter;
  localparam int MAX_SLOTS = 15;
  localparam int NUM_BINS  = 16;
  localparam int CAP_W     = 10;
  localparam int STUBS     = 2 * MAX_SLOTS;
  localparam int NVEC      = 10;

  typedef struct packed {
    logic [29:0] a;
    logic [29:0] b;
    logic [3:0]  win;
    logic [1:0]  algo;
    logic [9:0]  maxc;
    logic [29:0] ea;
    logic [29:0] eb;
  } vec_t;

  // bit 2*slot+pos; centre = win/2
  localparam vec_t TBL [NVEC] = '{
    '{30'h15,  30'h2,        4'd15, 2'd0, 10'd999, 30'h15,  30'h2},        // R5 no trim
    '{30'h155, 30'h70,       4'd5,  2'd1, 10'd999, 30'h14,  30'h30},       // R6 centre-out
    '{30'h101, 30'h4,        4'd5,  2'd1, 10'd999, 30'h101, 30'h4},        // R5 counts <=2
    '{30'h9,   30'hC00,      4'd15, 2'd0, 10'd2,   30'h0,   30'hC00},      // R8 all A cut
    '{30'hC2,  30'h100000,   4'd15, 2'd0, 10'd3,   30'h42,  30'h100000},   // R8 partial
    '{30'h41,  30'h120,      4'd3,  2'd0, 10'd999, 30'h1,   30'h20},       // R3 window mask
    '{30'h248, 30'h11,       4'd5,  2'd1, 10'd3,   30'h8,   30'h11},       // R6+R8
    '{30'hD,   30'h23,       4'd3,  2'd1, 10'd4,   30'hC,   30'h3},        // R6 pos order, R9
    '{30'h7,   30'h30000000, 4'd15, 2'd0, 10'd4,   30'h3,   30'h30000000}, // R8 at 4
    '{30'h155, 30'h0,        4'd5,  2'd2, 10'd999, 30'h155, 30'h0}         // R5 algo 2
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [STUBS-1:0] sec_a_i = '0;
  logic [STUBS-1:0] sec_b_i = '0;
  logic [3:0]       win_size_i = 4'd15;
  logic [1:0]       algo_sel_i = 2'd0;
  logic [CAP_W-1:0] max_total_i = 10'd999;
  logic             out_valid_o;
  logic [STUBS-1:0] sec_a_o, sec_b_o;
  logic [4:0]       cnt_a_o, cnt_b_o;
  logic [3:0]       bin_o;
  logic             done_o;

  int errors = 0;
  int checks = 0;
  int exp_bin = 0;

  stub_count_limiter #(.MAX_SLOTS(MAX_SLOTS), .NUM_BINS(NUM_BINS), .CAP_W(CAP_W)) dut (
    .clk_i, .rst_ni, .in_valid_i, .sec_a_i, .sec_b_i, .win_size_i, .algo_sel_i,
    .max_total_i, .out_valid_o, .sec_a_o, .sec_b_o, .cnt_a_o, .cnt_b_o, .bin_o, .done_o
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input vec_t v);
    @(negedge clk_i);
    sec_a_i = v.a; sec_b_i = v.b; win_size_i = v.win;
    algo_sel_i = v.algo; max_total_i = v.maxc; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t z;
    z = '{default: '0};
    z.win = 4'd15; z.maxc = 10'd999;
    #35;
    // R1 reset state
    check(out_valid_o == 0 && done_o == 0, "R1 valid/done", {out_valid_o, done_o}, 0);
    check(sec_a_o == 0 && sec_b_o == 0, "R1 stubs", sec_a_o | sec_b_o, 0);
    check(cnt_a_o == 0 && cnt_b_o == 0 && bin_o == 0, "R1 counts/bin", {cnt_a_o, cnt_b_o, bin_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      send(TBL[i]);
      check(out_valid_o == 1'b1, "R2 valid", out_valid_o, 1);
      check(sec_a_o == TBL[i].ea, $sformatf("R6/R8 vec%0d sec A", i), sec_a_o, TBL[i].ea);
      check(sec_b_o == TBL[i].eb, $sformatf("R6/R8 vec%0d sec B", i), sec_b_o, TBL[i].eb);
      check(32'(cnt_a_o) == $countones(TBL[i].ea) && 32'(cnt_b_o) == $countones(TBL[i].eb),
            $sformatf("R10 vec%0d counts", i), {cnt_a_o, cnt_b_o},
            {$countones(TBL[i].ea), $countones(TBL[i].eb)});
      check(32'(bin_o) == exp_bin, "R11 bin", bin_o, exp_bin);
      exp_bin++;
    end

    // R2 idle cycle keeps stubs, drops valid
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R2 idle valid", out_valid_o, 0);
    check(sec_a_o == TBL[NVEC-1].ea, "R2 idle hold", sec_a_o, TBL[NVEC-1].ea);

    // R7 trim with many stubs in both sections, R3 full window
    begin
      vec_t v;
      v = z; v.a = 30'h3FFFFFFF; v.b = 30'h3FFFFFFF; v.algo = 2'd1;
      send(v);
      // centre slot 7 both positions kept
      check(sec_a_o == 30'h0000C000, "R7 sec A full", sec_a_o, 30'h0000C000);
      check(sec_b_o == 30'h0000C000, "R7 sec B full", sec_b_o, 30'h0000C000);
      exp_bin++;
      // R9 exact total equal to max: no cap
      v = z; v.a = 30'h3; v.b = 30'h30; v.maxc = 10'd4;
      send(v);
      check(sec_a_o == 30'h3 && sec_b_o == 30'h30, "R9 equal max", {sec_a_o[15:0], sec_b_o[15:0]}, 32'h00030030);
      exp_bin++;
      // R8 section B above max alone: A fully cleared, B kept
      v = z; v.a = 30'h1; v.b = 30'h3F00; v.maxc = 10'd2;
      send(v);
      check(sec_a_o == 0 && sec_b_o == 30'h3F00, "R8 B over max", sec_a_o, 0);
      exp_bin++;
    end

    // R11 run to end of frame and across wrap
    while (exp_bin < NUM_BINS - 1) begin
      send(z);
      check(done_o == 1'b0, "R11 done early", done_o, 0);
      exp_bin++;
    end
    send(z);
    check(done_o == 1'b1 && bin_o == 4'(NUM_BINS - 1), "R11 done last", {done_o, bin_o}, {1'b1, 4'(NUM_BINS - 1)});
    send(z);
    check(done_o == 1'b0 && bin_o == 0, "R11 wrap", {done_o, bin_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule